// File: doc/BRIEF.md
# Single-Slope PWM Generator with Clamped Duty Extremes

This block produces a pulse-width modulated output from a free-running up-counter. The counter advances by one on every clock in which the enable input is high. It climbs from zero to a programmable period limit and then returns to zero, so each period spans limit+1 counts. A compare threshold sets how long the output stays high at the start of each period.

The mapping from threshold to duty cycle is clamped at both ends. A threshold of zero holds the output low for every count of every period. A threshold equal to the limit, or any larger value, holds it high for every count. For a threshold C between those two values, the output is high while the count is at or below C. That gives C+1 high counts per period, so a pulse of exactly one count cannot be produced.

Software-style writes to the threshold go into a holding register. The active threshold takes the new value only at the period boundary, so no period is ever cut short or stretched by a write. A strobe marks each boundary. The current count is also brought out, so that other logic can align to the waveform.

Top module: `fast_pwm_clamp`

## Requirements
- R1: Synchronous reset sets the count to 0, drives the output low, holds the boundary strobe low, and clears both the holding and the active threshold to 0. A write is therefore needed before the output can go high.
- R2: On each enabled clock the count goes up by one while it is below the limit. From the limit it goes to 0 on the next enabled clock, so one period lasts limit+1 enabled clocks.
- R3: While enable is low, the count holds its value, the boundary strobe stays low and the output does not change.
- R4: The boundary strobe is high for exactly the one cycle in which the count reads 0 just after a wrap from the limit. It is low in every other cycle.
- R5: An active threshold of 0 keeps the output low for every count of the period.
- R6: An active threshold that is nonzero and equal to or greater than the limit keeps the output high for every count of the period.
- R7: For an active threshold C with 0 < C < limit, the output is high exactly while count <= C, giving C+1 high counts per period. With a limit of 3, C=1 gives 2 of 4 and C=2 gives 3 of 4, and no threshold gives exactly 1 high count.
- R8: A write (write strobe high on a clock edge) updates only the holding register. The active threshold, and with it the output, changes only at the next wrap of the count to 0.
- R9: A write on the same edge as a wrap passes straight to the active threshold, so the written value governs the period that starts at that wrap.
- R10: If the limit is lowered below the present count, the next enabled clock returns the count to 0 and counts as a wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Count enable; the counter advances only while high |
| topVal | input | 8 | Period limit: the highest count before wrapping |
| cmpVal | input | 8 | Threshold value to be written |
| cmpWr | input | 1 | Write strobe for cmpVal into the holding register |
| pwmOut | output | 1 | Modulated output |
| count | output | 8 | Present counter value |
| wrapPulse | output | 1 | One-cycle strobe in the cycle after the count wraps to 0 |

## Verification
Two functions can fall on the same clock edge: a threshold write and a counter wrap. The bench makes them meet by stepping its own counter model until it sits at the limit and then raising the write strobe for just that edge. The result is judged by the number of high counts in the very next full period. That number must match the freshly written threshold and not the older held one. A separate run writes in the middle of a period and checks that the current period keeps its old duty.

// File: rtl/fpwm_pkg.sv
`timescale 1ns/100ps
package fpwm_pkg;

  // Strobes issued each cycle by the control to the datapath
  typedef struct packed {
    logic clrCount;    // return the counter to zero (wrap)
    logic incCount;    // advance the counter by one
    logic loadShadow;  // capture the written threshold
    logic loadActive;  // refresh the active threshold
    logic useDirect;   // take the active threshold from the write port
    logic wrapMark;    // register the boundary strobe
  } pwmStrobes_t;

endpackage

// File: rtl/fpwm_ctrl.sv
`timescale 1ns/100ps
module fpwm_ctrl
  import fpwm_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             en,
  input  logic [WIDTH-1:0] countQ,
  input  logic [WIDTH-1:0] topVal,
  input  logic             cmpWr,
  output pwmStrobes_t      strobes
);

  logic atOrPastTop;
  logic wrapNow;

  // ">=" rather than "==" so that a lowered limit still wraps at once
  assign atOrPastTop = (countQ >= topVal);
  assign wrapNow     = en && atOrPastTop;

  always_comb begin
    strobes            = '0;
    strobes.clrCount   = wrapNow;
    strobes.incCount   = en && !atOrPastTop;
    strobes.loadShadow = cmpWr;
    strobes.loadActive = wrapNow;
    strobes.useDirect  = wrapNow && cmpWr;
    strobes.wrapMark   = wrapNow;
  end

endmodule

// File: rtl/fpwm_level.sv
`timescale 1ns/100ps
module fpwm_level #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] countQ,
  input  logic [WIDTH-1:0] activeCmp,
  input  logic [WIDTH-1:0] topVal,
  output logic             level
);

  logic cmpZero;
  logic cmpFull;
  logic inWindow;

  assign cmpZero  = (activeCmp == '0);
  assign cmpFull  = (activeCmp >= topVal);
  assign inWindow = (countQ <= activeCmp);

  // Zero forces low; full scale forces high; otherwise high up to the threshold
  assign level = !cmpZero && (cmpFull || inWindow);

endmodule

// File: rtl/fpwm_datapath.sv
`timescale 1ns/100ps
module fpwm_datapath
  import fpwm_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  pwmStrobes_t      strobes,
  input  logic [WIDTH-1:0] cmpVal,
  input  logic [WIDTH-1:0] topVal,
  output logic [WIDTH-1:0] countQ,
  output logic [WIDTH-1:0] activeQ,
  output logic             wrapQ,
  output logic             pwmLevel
);

  localparam logic [WIDTH-1:0] STEP = WIDTH'(1);

  logic [WIDTH-1:0] shadowQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      countQ  <= '0;
      shadowQ <= '0;
      activeQ <= '0;
      wrapQ   <= 1'b0;
    end else begin
      if (strobes.clrCount)      countQ <= '0;
      else if (strobes.incCount) countQ <= countQ + STEP;

      if (strobes.loadShadow) shadowQ <= cmpVal;

      if (strobes.loadActive) activeQ <= strobes.useDirect ? cmpVal : shadowQ;

      wrapQ <= strobes.wrapMark;
    end
  end

  fpwm_level #(.WIDTH(WIDTH)) level_i (
    .countQ   (countQ),
    .activeCmp(activeQ),
    .topVal   (topVal),
    .level    (pwmLevel)
  );

endmodule

// File: rtl/fast_pwm_clamp.sv
`timescale 1ns/100ps
module fast_pwm_clamp
  import fpwm_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [WIDTH-1:0] topVal,
  input  logic [WIDTH-1:0] cmpVal,
  input  logic             cmpWr,
  output logic             pwmOut,
  output logic [WIDTH-1:0] count,
  output logic             wrapPulse
);

  pwmStrobes_t      strobes;
  logic [WIDTH-1:0] countQ;
  logic [WIDTH-1:0] activeCmp;

  fpwm_ctrl #(.WIDTH(WIDTH)) ctrl_i (
    .en     (en),
    .countQ (countQ),
    .topVal (topVal),
    .cmpWr  (cmpWr),
    .strobes(strobes)
  );

  fpwm_datapath #(.WIDTH(WIDTH)) dp_i (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .cmpVal  (cmpVal),
    .topVal  (topVal),
    .countQ  (countQ),
    .activeQ (activeCmp),
    .wrapQ   (wrapPulse),
    .pwmLevel(pwmOut)
  );

  assign count = countQ;

endmodule

// File: rtl/fpwm_checker.sv
`timescale 1ns/100ps
module fpwm_checker #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic [WIDTH-1:0] topVal,
  input logic [WIDTH-1:0] cmpVal,
  input logic             cmpWr,
  input logic             pwmOut,
  input logic [WIDTH-1:0] count,
  input logic             wrapPulse,
  input logic [WIDTH-1:0] activeCmp
);

  assert_reset_state_R1: assert property (@(posedge clk)
    $past(rst) |-> (count == '0 && !pwmOut && !wrapPulse && activeCmp == '0));

  assert_count_step_R2: assert property (@(posedge clk) disable iff (rst)
    (en && count < topVal) |=> (count == $past(count) + WIDTH'(1)));

  assert_count_wrap_R10: assert property (@(posedge clk) disable iff (rst)
    (en && count >= topVal) |=> (count == '0 && wrapPulse));

  assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!en && $stable(topVal)) |=> ($stable(count) && !wrapPulse && $stable(pwmOut)));

  assert_wrap_zero_R4: assert property (@(posedge clk) disable iff (rst)
    wrapPulse |-> (count == '0));

  assert_zero_low_R5: assert property (@(posedge clk) disable iff (rst)
    (activeCmp == '0) |-> !pwmOut);

  assert_full_high_R6: assert property (@(posedge clk) disable iff (rst)
    (activeCmp != '0 && activeCmp >= topVal) |-> pwmOut);

  assert_window_R7: assert property (@(posedge clk) disable iff (rst)
    (pwmOut && activeCmp < topVal) |-> (count <= activeCmp));

  assert_active_at_wrap_R8: assert property (@(posedge clk) disable iff (rst)
    !$stable(activeCmp) |-> wrapPulse);

  assert_forward_R9: assert property (@(posedge clk) disable iff (rst)
    (en && count >= topVal && cmpWr) |=> (activeCmp == $past(cmpVal)));

endmodule

bind fast_pwm_clamp fpwm_checker #(.WIDTH(WIDTH)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .en       (en),
  .topVal   (topVal),
  .cmpVal   (cmpVal),
  .cmpWr    (cmpWr),
  .pwmOut   (pwmOut),
  .count    (count),
  .wrapPulse(wrapPulse),
  .activeCmp(activeCmp)
);

// File: tb/fast_pwm_clamp_tb_top.sv
`timescale 1ns/100ps
module fast_pwm_clamp_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en = 1'b0;
  logic [7:0] topVal = 8'd3;
  logic [7:0] cmpVal = 8'd0;
  logic       cmpWr = 1'b0;
  logic       pwmOut;
  logic [7:0] count;
  logic       wrapPulse;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;  // 4 ns period, 250 MHz

  fast_pwm_clamp #(.WIDTH(8)) dut_i (
    .clk(clk), .rst(rst), .en(en), .topVal(topVal), .cmpVal(cmpVal),
    .cmpWr(cmpWr), .pwmOut(pwmOut), .count(count), .wrapPulse(wrapPulse)
  );

  typedef struct {
    logic [7:0] cnt;
    logic       pwm;
    logic       wrap;
    string      tag;
  } expItem_t;

  expItem_t expQ[$];

  // bench model state
  logic [7:0] mCnt = 0, mShadow = 0, mActive = 0;
  logic       mWrap = 0;

  int runHigh = 0;
  int lastHigh = -1;

  // drive one clock: set inputs at negedge, predict the state after the next edge
  task automatic stepCycle(input logic r, input logic e, input logic [7:0] t,
                           input logic [7:0] c, input logic w, input string tag);
    bit wrapNow;
    expItem_t it;
    @(negedge clk);
    rst = r; en = e; topVal = t; cmpVal = c; cmpWr = w;
    if (r) begin
      mCnt = 0; mShadow = 0; mActive = 0; mWrap = 0;
    end else begin
      wrapNow = e && (mCnt >= t);
      if (wrapNow) mActive = w ? c : mShadow;
      if (w) mShadow = c;
      if (wrapNow) mCnt = 0;
      else if (e) mCnt = mCnt + 8'd1;
      mWrap = wrapNow;
    end
    it.cnt  = mCnt;
    it.wrap = mWrap;
    it.pwm  = (mActive != 0) && ((mActive >= t) || (mCnt <= mActive));
    it.tag  = tag;
    expQ.push_back(it);
  endtask

  task automatic runCycles(input int n, input string tag);
    for (int i = 0; i < n; i++) stepCycle(1'b0, 1'b1, topVal, cmpVal, 1'b0, tag);
  endtask

  task automatic writeCmp(input logic [7:0] c, input string tag);
    stepCycle(1'b0, 1'b1, topVal, c, 1'b1, tag);
  endtask

  task automatic checkDuty(input int expected, input string tag);
    @(posedge clk);
    #1.5;
    checks++;
    if (lastHigh != expected) begin
      fails++;
      $display("FAIL %s: high counts per period actual %0d expected %0d", tag, lastHigh, expected);
    end
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  // monitor: compare every cycle against the queued prediction
  initial begin
    expItem_t it;
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) begin
        it = expQ.pop_front();
        checks++;
        if (count !== it.cnt || pwmOut !== it.pwm || wrapPulse !== it.wrap) begin
          fails++;
          $display("FAIL %s: count %0d exp %0d, pwm %0b exp %0b, wrap %0b exp %0b",
                   it.tag, count, it.cnt, pwmOut, it.pwm, wrapPulse, it.wrap);
        end
        if (wrapPulse) begin
          lastHigh = runHigh;
          runHigh = pwmOut ? 1 : 0;
        end else begin
          runHigh += pwmOut ? 1 : 0;
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete, actual timeout expected finish");
    finish();
  end

  initial begin
    // R1: reset state
    for (int i = 0; i < 3; i++) stepCycle(1'b1, 1'b0, 8'd3, 8'd0, 1'b0, "R1");
    runCycles(8, "R1_R2");
    checkDuty(0, "R1");

    // R8: write mid-period, takes effect at the wrap; R7 duty with TOP=3
    runCycles(1, "R8");
    writeCmp(8'd1, "R8");
    runCycles(12, "R7");
    checkDuty(2, "R7");
    runCycles(2, "R8");
    writeCmp(8'd2, "R8");
    runCycles(12, "R7");
    checkDuty(3, "R7");

    // R5: zero threshold
    writeCmp(8'd0, "R5");
    runCycles(12, "R5");
    checkDuty(0, "R5");

    // R6: threshold equal to and above the limit
    writeCmp(8'd3, "R6");
    runCycles(12, "R6");
    checkDuty(4, "R6");
    writeCmp(8'd200, "R6");
    runCycles(12, "R6");
    checkDuty(4, "R6");

    // R7: no threshold yields a single high count
    for (int c = 0; c < 4; c++) begin
      writeCmp(8'(c), "R7");
      runCycles(12, "R7");
      checkDuty((c == 0) ? 0 : c + 1, "R7");
    end

    // R3: enable low holds everything
    writeCmp(8'd1, "R3");
    runCycles(5, "R3");
    for (int i = 0; i < 6; i++) stepCycle(1'b0, 1'b0, topVal, cmpVal, 1'b0, "R3");
    runCycles(9, "R3");

    // R9: write coincident with a wrap governs the next period
    while (mCnt != topVal) stepCycle(1'b0, 1'b1, topVal, cmpVal, 1'b0, "R9");
    stepCycle(1'b0, 1'b1, topVal, 8'd2, 1'b1, "R9");
    runCycles(4, "R9");
    checkDuty(3, "R9");

    // R2/R4: full-range period
    stepCycle(1'b0, 1'b1, 8'd255, 8'd128, 1'b1, "R2");
    runCycles(3 * 256, "R4");
    checkDuty(129, "R2");

    // R10: limit lowered below the present count
    while (mCnt != 8'd60) stepCycle(1'b0, 1'b1, 8'd200, cmpVal, 1'b0, "R10");
    stepCycle(1'b0, 1'b1, 8'd10, cmpVal, 1'b0, "R10");
    runCycles(30, "R10");
    checkDuty(11, "R10");

    // drain
    @(posedge clk);
    #1.5;
    finish();
  end

endmodule